// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the operating-mode state machine of a LIN slave-node transceiver that has its own supply regulator. It takes digitized flags from the analog side and the pin levels from the node's microcontroller. It decides which of five modes the node is in: Unpowered, Fail-safe, Normal, Silent or Sleep. From that mode it drives the regulator enable, the bus transmitter enable, a select for what the receive-data pin shows, and a flag that records that the node woke up.

The microcontroller selects Normal by driving enable high. When it drops enable, the level on the transmit-data pin at that moment chooses the low-power mode. With transmit data high the node goes to Silent and keeps the regulator on. With transmit data low it goes to Sleep and turns the regulator off. In Silent or Sleep, a bus held dominant for about 90 µs without a break wakes the node into Fail-safe. A local wake-up request also wakes it, but only from Sleep. The 90 µs window is counted in clock cycles derived from a clock-frequency parameter. The enable, transmit-data, bus-level and local-wake inputs each pass through a two-flop synchronizer before the state machine uses them. The supply flags and the reset-output flag are used directly.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_n is low and afterwards until the supply rises, mode is 0 (Unpowered), regEn and txEn are 0, rxdSel is 3 (output off) and wakeFlag is 0.
- R2: In Unpowered, vsHigh high with vsAlive high moves mode to 1 (Fail-safe) on the next clock edge. In any mode, vsAlive low moves mode to 0 on the next edge and clears wakeFlag.
- R3: enPin, txdPin, busLevel and localWake are seen by the state machine through two flops. A change on enPin set between edges changes mode on the third rising edge after it, not earlier.
- R4: Fail-safe with synchronized enable high and resetLow low moves to mode 2 (Normal). Silent with synchronized enable high moves to Normal when neither resetLow nor a bus wake-up is present.
- R5: In Normal with synchronized enable low, a synchronized txdPin of 1 moves to mode 3 (Silent) and a synchronized txdPin of 0 moves to mode 4 (Sleep).
- R6: resetLow high moves Normal or Silent to Fail-safe on the next edge. In Silent it takes priority over a bus wake-up in the same cycle, and then wakeFlag stays 0. resetLow has no effect in Sleep.
- R7: In Silent or Sleep, a bus wake-up is recognised on the WAKE_CYCLES-th consecutive synchronized dominant sample (busLevel 0). WAKE_CYCLES is CLK_HZ*WAKE_US/1e6, which is 11250 at the defaults. The mode then becomes Fail-safe with wakeFlag set. A recessive sample restarts the count, so WAKE_CYCLES-1 dominant samples leave the mode unchanged.
- R8: A synchronized localWake in Sleep moves to Fail-safe and sets wakeFlag. In Silent, localWake has no effect.
- R9: enPin has no effect in Sleep.
- R10: regEn is 1 in Fail-safe, Normal and Silent, and 0 in Sleep and Unpowered.
- R11: txEn is 1 only in Normal while vsHigh is high. It follows vsHigh in the same cycle.
- R12: rxdSel is 0 (pass bus level) in Normal, 1 (forced high) in Silent and in Fail-safe without wakeFlag, 2 (forced low) in Sleep and in Fail-safe with wakeFlag, and 3 (off) in Unpowered.
- R13: wakeFlag is cleared on the same edge that enters Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsHigh | input | 1 | Supply above the 5 V operating threshold |
| vsAlive | input | 1 | Supply above the 3.7 V power-loss threshold |
| enPin | input | 1 | Enable pin level |
| txdPin | input | 1 | Transmit-data pin level |
| busLevel | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| localWake | input | 1 | Local wake-up request |
| resetLow | input | 1 | Reset output is being held low |
| mode | output | 3 | Current mode: 0 Unpowered, 1 Fail-safe, 2 Normal, 3 Silent, 4 Sleep |
| regEn | output | 1 | Regulator enable |
| txEn | output | 1 | Bus transmitter enable |
| rxdSel | output | 2 | Receive-data select: 0 pass, 1 high, 2 low, 3 off |
| wakeFlag | output | 1 | Node has woken up since it last entered Normal |

## Verification
In Silent, the completion of a bus wake-up and an asserted reset output can land in the same cycle. Reset must win: the node goes to Fail-safe but the wake-up flag stays clear. The bench holds the bus dominant in Silent and watches its own reference model for the cycle whose next edge would complete the filter. It raises resetLow in exactly that cycle. It then expects Fail-safe with wakeFlag 0 and rxdSel 1, as well as a match against the model on every clock.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_SAFE  = 3'd1,
    MODE_RUN   = 3'd2,
    MODE_QUIET = 3'd3,
    MODE_DOZE  = 3'd4
  } linMode_t;

  typedef enum logic [1:0] {
    RXD_PASS = 2'd0,
    RXD_HIGH = 2'd1,
    RXD_LOW  = 2'd2,
    RXD_OFF  = 2'd3
  } rxdSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic filtRun;
    logic setWake;
    logic clrWake;
  } ctlStrobe_t;

  // bit positions of the synchronized pin vector
  localparam int PIN_EN   = 0;
  localparam int PIN_TXD  = 1;
  localparam int PIN_BUS  = 2;
  localparam int PIN_LWK  = 3;
  localparam int PIN_W    = 4;

endpackage

// File: rtl/lin_mode_dp.sv
module lin_mode_dp
  import lin_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 11250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pinRaw,
  input  ctlStrobe_t       strb,
  output logic [PIN_W-1:0] pinSync,
  output logic             busWake,
  output logic             wakeFlag
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WAKE_CYCLES);

  // synchronizer chain, one register stage per generate step
  logic [PIN_W-1:0] syncStage [SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncStage[g] <= '0;
          else        syncStage[g] <= pinRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncStage[g] <= '0;
          else        syncStage[g] <= syncStage[g-1];
        end
      end
    end
  endgenerate

  assign pinSync = syncStage[SYNC_STAGES-1];

  // dominant-duration filter
  logic [CNT_W-1:0] domCnt;
  logic             busDom;

  assign busDom  = ~pinSync[PIN_BUS];
  assign busWake = strb.filtRun && busDom && (domCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      domCnt <= '0;
    end else if (!strb.filtRun || !busDom) begin
      domCnt <= '0;
    end else if (domCnt != CNT_SAT) begin
      domCnt <= domCnt + 1'b1;
    end
  end

  // wake-up record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wakeFlag <= 1'b0;
    else if (strb.clrWake) wakeFlag <= 1'b0;
    else if (strb.setWake) wakeFlag <= 1'b1;
  end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsHigh,
  input  logic             vsAlive,
  input  logic             resetLow,
  input  logic [PIN_W-1:0] pinSync,
  input  logic             busWake,
  input  logic             wakeFlag,
  output ctlStrobe_t       strb,
  output linMode_t         modeQ,
  output logic             regEn,
  output logic             txEn,
  output rxdSel_t          rxdSel
);

  linMode_t modeNxt;
  logic     enS, txdS, lwkS;
  logic     wakeEntry;

  assign enS  = pinSync[PIN_EN];
  assign txdS = pinSync[PIN_TXD];
  assign lwkS = pinSync[PIN_LWK];

  always_comb begin
    modeNxt   = modeQ;
    wakeEntry = 1'b0;
    if (!vsAlive) begin
      modeNxt = MODE_OFF;
    end else begin
      unique case (modeQ)
        MODE_OFF: begin
          if (vsHigh) modeNxt = MODE_SAFE;
        end
        MODE_SAFE: begin
          if (enS && !resetLow) modeNxt = MODE_RUN;
        end
        MODE_RUN: begin
          if (resetLow)  modeNxt = MODE_SAFE;
          else if (!enS) modeNxt = txdS ? MODE_QUIET : MODE_DOZE;
        end
        MODE_QUIET: begin
          if (resetLow) begin
            modeNxt = MODE_SAFE;
          end else if (busWake) begin
            modeNxt   = MODE_SAFE;
            wakeEntry = 1'b1;
          end else if (enS) begin
            modeNxt = MODE_RUN;
          end
        end
        MODE_DOZE: begin
          if (busWake || lwkS) begin
            modeNxt   = MODE_SAFE;
            wakeEntry = 1'b1;
          end
        end
        default: modeNxt = MODE_OFF;
      endcase
    end
  end

  always_comb begin
    strb.filtRun = (modeQ == MODE_QUIET) || (modeQ == MODE_DOZE);
    strb.setWake = wakeEntry;
    strb.clrWake = ((modeNxt == MODE_RUN) && (modeQ != MODE_RUN)) ||
                   (modeNxt == MODE_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeQ <= MODE_OFF;
    else        modeQ <= modeNxt;
  end

  // output decode
  always_comb begin
    regEn  = 1'b0;
    txEn   = 1'b0;
    rxdSel = RXD_OFF;
    unique case (modeQ)
      MODE_SAFE: begin
        regEn  = 1'b1;
        rxdSel = wakeFlag ? RXD_LOW : RXD_HIGH;
      end
      MODE_RUN: begin
        regEn  = 1'b1;
        txEn   = vsHigh;
        rxdSel = RXD_PASS;
      end
      MODE_QUIET: begin
        regEn  = 1'b1;
        rxdSel = RXD_HIGH;
      end
      MODE_DOZE: begin
        rxdSel = RXD_LOW;
      end
      default: begin
        rxdSel = RXD_OFF;
      end
    endcase
  end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int WAKE_US     = 90,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsHigh,
  input  logic       vsAlive,
  input  logic       enPin,
  input  logic       txdPin,
  input  logic       busLevel,
  input  logic       localWake,
  input  logic       resetLow,
  output logic [2:0] mode,
  output logic       regEn,
  output logic       txEn,
  output logic [1:0] rxdSel,
  output logic       wakeFlag
);

  localparam longint WAKE_RAW    = (longint'(CLK_HZ) * longint'(WAKE_US)) / 64'sd1000000;
  localparam int     WAKE_CYCLES = (WAKE_RAW < 2) ? 2 : int'(WAKE_RAW);

  logic [PIN_W-1:0] pinRaw;
  logic [PIN_W-1:0] pinSync;
  ctlStrobe_t       strb;
  logic             busWake;
  linMode_t         modeQ;
  rxdSel_t          rxdSelQ;

  always_comb begin
    pinRaw          = '0;
    pinRaw[PIN_EN]  = enPin;
    pinRaw[PIN_TXD] = txdPin;
    pinRaw[PIN_BUS] = busLevel;
    pinRaw[PIN_LWK] = localWake;
  end

  lin_mode_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinRaw   (pinRaw),
    .strb     (strb),
    .pinSync  (pinSync),
    .busWake  (busWake),
    .wakeFlag (wakeFlag)
  );

  lin_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsHigh   (vsHigh),
    .vsAlive  (vsAlive),
    .resetLow (resetLow),
    .pinSync  (pinSync),
    .busWake  (busWake),
    .wakeFlag (wakeFlag),
    .strb     (strb),
    .modeQ    (modeQ),
    .regEn    (regEn),
    .txEn     (txEn),
    .rxdSel   (rxdSelQ)
  );

  assign mode   = modeQ;
  assign rxdSel = rxdSelQ;

endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk
  import lin_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       vsAlive,
  input logic       vsHigh,
  input logic       resetLow,
  input logic [2:0] mode,
  input logic       regEn,
  input logic       txEn,
  input logic [1:0] rxdSel,
  input logic       wakeFlag,
  input logic       busWake
);

  // R2
  brownout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsAlive |=> (mode == MODE_OFF) && !wakeFlag);

  // R1
  unpowered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !regEn && !txEn && !wakeFlag);

  // R6
  reset_to_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsAlive && resetLow && ((mode == MODE_RUN) || (mode == MODE_QUIET)))
      |=> (mode == MODE_SAFE) && !$rose(wakeFlag));

  // R7
  bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsAlive && busWake && (mode == MODE_DOZE)) |=> (mode == MODE_SAFE) && wakeFlag);

  // R13
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_RUN) && ($past(mode) != MODE_RUN)) |-> !wakeFlag);

  // R12
  wake_rxd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SAFE) && wakeFlag) |-> (rxdSel == RXD_LOW));

  // R11
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txEn |-> vsHigh && regEn && (rxdSel == RXD_PASS));

  // R9
  sleep_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_DOZE) && $past(mode) == MODE_DOZE) |-> !regEn);

endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vsAlive  (vsAlive),
  .vsHigh   (vsHigh),
  .resetLow (resetLow),
  .mode     (mode),
  .regEn    (regEn),
  .txEn     (txEn),
  .rxdSel   (rxdSel),
  .wakeFlag (wakeFlag),
  .busWake  (busWake)
);

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;

  localparam int CLK_HZ  = 125_000_000;
  localparam int WAKE_US = 90;
  localparam int LIMIT   = int'((longint'(CLK_HZ) * WAKE_US) / 1000000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsHigh = 1'b0, vsAlive = 1'b0, enPin = 1'b0, txdPin = 1'b1;
  logic busLevel = 1'b1, localWake = 1'b0, resetLow = 1'b0;
  logic [2:0] mode;
  logic regEn, txEn, wakeFlag;
  logic [1:0] rxdSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lin_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .vsHigh(vsHigh), .vsAlive(vsAlive),
    .enPin(enPin), .txdPin(txdPin), .busLevel(busLevel),
    .localWake(localWake), .resetLow(resetLow), .mode(mode),
    .regEn(regEn), .txEn(txEn), .rxdSel(rxdSel), .wakeFlag(wakeFlag)
  );

  // behavioural reference: pin history queue, mode number, dominant run length
  bit [3:0] pinHist [$];
  int  mM, mRun, nm;
  bit  mWf, e, t, b, l, hit, watching, setw;
  bit [3:0] seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mM = 0; mRun = 0; mWf = 0;
      pinHist.delete();
      pinHist.push_back(4'b0000);
      pinHist.push_back(4'b0000);
    end else begin
      seen = pinHist[0];
      e = seen[0]; t = seen[1]; b = seen[2]; l = seen[3];
      watching = (mM == 3) || (mM == 4);
      hit = watching && !b && (mRun == LIMIT - 1);
      setw = 0;
      nm = mM;
      if (!vsAlive) nm = 0;
      else if (mM == 0) begin if (vsHigh) nm = 1; end
      else if (mM == 1) begin if (e && !resetLow) nm = 2; end
      else if (mM == 2) begin
        if (resetLow) nm = 1;
        else if (!e) nm = t ? 3 : 4;
      end else if (mM == 3) begin
        if (resetLow) nm = 1;
        else if (hit) begin nm = 1; setw = 1; end
        else if (e) nm = 2;
      end else if (mM == 4) begin
        if (hit || l) begin nm = 1; setw = 1; end
      end
      if ((nm == 2 && mM != 2) || nm == 0) mWf = 0;
      else if (setw) mWf = 1;
      if (watching && !b) begin if (mRun < LIMIT) mRun++; end
      else mRun = 0;
      mM = nm;
      void'(pinHist.pop_front());
      pinHist.push_back({localWake, busLevel, txdPin, enPin});
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRxd();
    if (mM == 2) return 0;
    if (mM == 4) return 2;
    if (mM == 1) return mWf ? 2 : 1;
    if (mM == 0) return 3;
    return 1;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 mode vs model", int'(mode), mM);
      chk("R10 regEn vs model", int'(regEn), int'(mM == 1 || mM == 2 || mM == 3));
      chk("R11 txEn vs model", int'(txEn), int'(mM == 2 && vsHigh));
      chk("R12 rxdSel vs model", int'(rxdSel), expRxd());
      chk("R13 wakeFlag vs model", int'(wakeFlag), int'(mWf));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 mode", int'(mode), 0);
    chk("R1 regEn", int'(regEn), 0);
    chk("R1 rxdSel", int'(rxdSel), 3);
    rst_n = 1'b1;
    tick(3);
    chk("R1 still unpowered", int'(mode), 0);

    vsAlive = 1'b1; vsHigh = 1'b1;
    tick(1);
    chk("R2 powered to fail-safe", int'(mode), 1);
    chk("R10 regEn fail-safe", int'(regEn), 1);
    chk("R12 rxd high fail-safe", int'(rxdSel), 1);

    enPin = 1'b1;
    tick(2);
    chk("R3 not yet normal", int'(mode), 1);
    tick(1);
    chk("R3 R4 normal on third edge", int'(mode), 2);
    chk("R12 rxd pass", int'(rxdSel), 0);
    chk("R11 txEn normal", int'(txEn), 1);
    vsHigh = 1'b0;
    #1;
    chk("R11 txEn off on undervoltage", int'(txEn), 0);
    tick(1);
    vsHigh = 1'b1;

    enPin = 1'b0; txdPin = 1'b1;
    tick(4);
    chk("R5 silent", int'(mode), 3);
    localWake = 1'b1;
    tick(5);
    chk("R8 local wake ignored in silent", int'(mode), 3);
    localWake = 1'b0;
    enPin = 1'b1;
    tick(4);
    chk("R4 silent to normal", int'(mode), 2);

    enPin = 1'b0; txdPin = 1'b0;
    tick(4);
    chk("R5 sleep", int'(mode), 4);
    chk("R10 regEn off sleep", int'(regEn), 0);
    chk("R12 rxd low sleep", int'(rxdSel), 2);
    txdPin = 1'b1;
    resetLow = 1'b1; enPin = 1'b1;
    tick(6);
    chk("R6 reset ignored in sleep", int'(mode), 4);
    chk("R9 enable ignored in sleep", int'(mode), 4);
    resetLow = 1'b0; enPin = 1'b0;
    tick(4);

    busLevel = 1'b0;
    tick(LIMIT - 1);
    busLevel = 1'b1;
    tick(6);
    chk("R7 short dominant no wake", int'(mode), 4);

    busLevel = 1'b0;
    tick(LIMIT + 1);
    chk("R7 not yet woken", int'(mode), 4);
    tick(1);
    chk("R7 bus wake to fail-safe", int'(mode), 1);
    chk("R7 wakeFlag set", int'(wakeFlag), 1);
    chk("R12 rxd low after wake", int'(rxdSel), 2);
    busLevel = 1'b1;

    enPin = 1'b1;
    tick(4);
    chk("R13 normal clears wakeFlag", int'(wakeFlag), 0);
    enPin = 1'b0; txdPin = 1'b1;
    tick(4);
    chk("R5 silent again", int'(mode), 3);
    resetLow = 1'b1;
    tick(1);
    chk("R6 reset silent to fail-safe", int'(mode), 1);
    resetLow = 1'b0;
    enPin = 1'b1;
    tick(4);
    enPin = 1'b0;
    tick(4);
    chk("R5 silent third time", int'(mode), 3);

    // collision: reset and bus wake completion in the same cycle
    busLevel = 1'b0;
    while (!(mM == 3 && pinHist[0][2] == 1'b0 && mRun == LIMIT - 1)) tick(1);
    resetLow = 1'b1;
    tick(1);
    chk("R6 collision fail-safe", int'(mode), 1);
    chk("R6 collision no wakeFlag", int'(wakeFlag), 0);
    resetLow = 1'b0; busLevel = 1'b1;

    enPin = 1'b1;
    tick(4);
    enPin = 1'b0; txdPin = 1'b0;
    tick(4);
    chk("R5 sleep again", int'(mode), 4);
    txdPin = 1'b1;
    localWake = 1'b1;
    tick(3);
    chk("R8 local wake from sleep", int'(mode), 1);
    chk("R8 wakeFlag on local wake", int'(wakeFlag), 1);
    localWake = 1'b0;

    vsAlive = 1'b0;
    tick(1);
    chk("R2 brownout to unpowered", int'(mode), 0);
    chk("R2 wakeFlag cleared", int'(wakeFlag), 0);
    chk("R12 rxd off unpowered", int'(rxdSel), 3);
    tick(2);
    finish_run();
  end

endmodule